// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins controlled through a simple 32-bit register bus. Software loads an output latch, chooses a direction for each pin, and reads the pin levels back after a two-stage synchronizer. The bank also has a separate read-only register that returns the output latch. That register exists because the pin-level register shows the pad even on pins that the block drives. As a result, a value just written does not show there until it has travelled out and back through the synchronizer.

Each pin has its own interrupt detector. The trigger mode is spread across three per-pin bit registers. A pin can trigger on a rising edge, a falling edge, either edge, a high level or a low level. A detected event latches a sticky status bit, but only while the pin's enable bit is set. Software clears a status bit by writing 1 to it. A single interrupt line is the OR of every status bit whose enable is set.

The bus has a write strobe, a byte address and write data. Read data is a combinational function of the address, so it is valid in the same cycle the address is presented. Writes take effect at the next rising clock edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is low at a clock edge, the direction, enable, trigger-type and status registers and the output latch clear to zero, so `pad_oe`, `pad_out` and `irq_out` are all 0 after reset.
- R2: A write to offset 0x00 loads the output latch, which drives `pad_out` from the next edge. Offset 0x08 reads the latch back. A write to 0x08 changes nothing.
- R3: Offset 0x04 holds one direction bit per pin: 1 means output and 0 means input. The register drives `pad_oe` bit for bit.
- R4: A read at offset 0x00 returns the pad levels through two synchronizer flops. This is true even for pins driven as outputs. A pad change made after edge N is visible in the read data after edge N+2, but not after edge N+1.
- R5: Edge modes, with the code written {type2,type1,type0}: 000 triggers on a falling edge, 001 on a rising edge, and 101 (and also 100) on either edge. An edge is the synchronized sample differing from the previous sample. The status bit is set at the edge after the sample changes, which is three edges after the pad change.
- R6: Level modes: 010 triggers while the synchronized level is low and 011 while it is high. Codes 110 and 111 behave like 010 and 011, because type2 is ignored when type1 is 1.
- R7: An event sets a status bit only if that pin's enable bit held 1 in the cycle of the event. A disabled pin keeps its status unchanged whatever its input does.
- R8: Writing 1 to a status bit clears it. Writing 0 has no effect. A clear takes priority over an event in the same cycle. An active level therefore sets the bit again in the following cycle.
- R9: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit set. Clearing an enable bit masks that pin's status without clearing it.
- R10: The interrupt registers sit at these offsets: enable 0x10, type0 0x14, type1 0x18, type2 0x1C and status 0x20. All are readable. Any other offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch toward the pad drivers |
| pad_oe | output | 32 | Per-pin output enable (1 = drive) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Several directed patterns exercise the trigger logic, with five neighbouring pins each set to a different mode:
- A single pad step raises edges of both polarities together. This separates falling-only, rising-only and both-edge detection.
- The reverse step shows that the one-sided modes ignore the opposite edge.
- Holding a level through a clear separates sticky edge status from re-asserting level status.
- Toggling pins while their enable is off shows that the gate applies when the status is set, not when it is read.

A long random phase then flips a few pad bits and issues random register writes every cycle, including status clears, writes to the read-only register and unmapped offsets. Its results are compared every cycle with a bench model of the requirements.

// File: rtl/gpio_bank_pkg.sv
// Package gpio_bank_pkg
// Shared register offsets and trigger-mode codes for the GPIO interrupt bank.
// Assumes byte addressing on the register bus with 32-bit aligned registers.
package gpio_bank_pkg;

    // Offsets of the port-control registers
    localparam logic [7:0] OFS_VALUE    = 8'h00;  // read: synchronized pads, write: output latch
    localparam logic [7:0] OFS_DIR      = 8'h04;  // 1 = output
    localparam logic [7:0] OFS_LATCH    = 8'h08;  // read-only copy of the output latch

    // The interrupt group: a base plus fixed relative offsets
    localparam logic [7:0] OFS_IRQ_BASE = 8'h10;
    localparam logic [7:0] IRQ_EN       = 8'h00;
    localparam logic [7:0] IRQ_T0       = 8'h04;
    localparam logic [7:0] IRQ_T1       = 8'h08;
    localparam logic [7:0] IRQ_T2       = 8'h0C;
    localparam logic [7:0] IRQ_STAT     = 8'h10;

    // Trigger codes written as {type2, type1, type0}
    typedef enum logic [2:0] {
        TRIG_FALL = 3'b000,
        TRIG_RISE = 3'b001,
        TRIG_LOW  = 3'b010,
        TRIG_HIGH = 3'b011,
        TRIG_BOTH = 3'b101
    } trig_mode_e;

endpackage

// File: rtl/gpio_pad_sync.sv
// Module gpio_pad_sync
// Brings asynchronous pad levels into the clock domain through a chain of
// STAGES flops per bit. Assumes each pad bit is independent; no bus coherency
// across bits is promised.
module gpio_pad_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pad levels one stage down the chain each clock
    always_ff @(posedge clk) begin : p_chain
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign d_sync = chain_q[LAST];

    // R4: the sampled output is the previous content of the stage before it
    assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        d_sync == $past(chain_q[LAST-1]));

endmodule

// File: rtl/gpio_bank_regs.sv
// Module gpio_bank_regs
// Software-visible register file of the GPIO bank: output latch, direction,
// interrupt enable and the three trigger-type planes. It decodes bus writes,
// produces the write-one-to-clear mask for the status register and forms the
// combinational read data. Assumes NPINS <= DATA_W; unused upper read bits are 0.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_sampled,
    input  logic [NPINS-1:0]  irq_status,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  en_q,
    output logic [NPINS-1:0]  t0_q,
    output logic [NPINS-1:0]  t1_q,
    output logic [NPINS-1:0]  t2_q,
    output logic [NPINS-1:0]  clr_mask
);

    localparam logic [ADDR_W-1:0] A_VAL   = ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(OFS_LATCH);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_IRQ_BASE + IRQ_EN);
    localparam logic [ADDR_W-1:0] A_T0    = ADDR_W'(OFS_IRQ_BASE + IRQ_T0);
    localparam logic [ADDR_W-1:0] A_T1    = ADDR_W'(OFS_IRQ_BASE + IRQ_T1);
    localparam logic [ADDR_W-1:0] A_T2    = ADDR_W'(OFS_IRQ_BASE + IRQ_T2);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_IRQ_BASE + IRQ_STAT);

    logic [NPINS-1:0] wdata_pins;
    assign wdata_pins = bus_wdata[NPINS-1:0];

    // Widen a pin vector to the bus width
    function automatic logic [DATA_W-1:0] zext(input logic [NPINS-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    // Update the writable registers on a bus write
    always_ff @(posedge clk) begin : p_regs
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            en_q    <= '0;
            t0_q    <= '0;
            t1_q    <= '0;
            t2_q    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_VAL:   latch_q <= wdata_pins;
                A_DIR:   dir_q   <= wdata_pins;
                A_EN:    en_q    <= wdata_pins;
                A_T0:    t0_q    <= wdata_pins;
                A_T1:    t1_q    <= wdata_pins;
                A_T2:    t2_q    <= wdata_pins;
                default: ;
            endcase
        end
    end

    // Form the write-one-to-clear mask for the status register
    always_comb begin : p_clear
        clr_mask = '0;
        if (bus_wr && (bus_addr == A_STAT)) begin
            clr_mask = wdata_pins;
        end
    end

    // Select the read data for the presented address
    always_comb begin : p_read
        case (bus_addr)
            A_VAL:   bus_rdata = zext(pin_sampled);
            A_DIR:   bus_rdata = zext(dir_q);
            A_LATCH: bus_rdata = zext(latch_q);
            A_EN:    bus_rdata = zext(en_q);
            A_T0:    bus_rdata = zext(t0_q);
            A_T1:    bus_rdata = zext(t1_q);
            A_T2:    bus_rdata = zext(t2_q);
            A_STAT:  bus_rdata = zext(irq_status);
            default: bus_rdata = '0;
        endcase
    end

    // R1: the first cycle after reset starts from cleared control state
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (latch_q == '0 && dir_q == '0 && en_q == '0 &&
                           t0_q == '0 && t1_q == '0 && t2_q == '0));

    // R2: a value-register write lands in the latch at the next edge
    assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_VAL) |=> latch_q == $past(wdata_pins));

    // R2: the latch readback register cannot be written
    assert_latch_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LATCH) |=> $stable(latch_q));

    // R10: an unmapped address never returns data
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > A_STAT) |-> bus_rdata == '0);

endmodule

// File: rtl/gpio_irq_detect.sv
// Module gpio_irq_detect
// Per-pin event detection and sticky status for the GPIO bank. It keeps the
// previous synchronized sample for edge detection, decodes each pin's trigger
// code, and sets status bits gated by enable. A same-cycle clear wins over an
// event. Assumes its inputs are already synchronous to clk.
module gpio_irq_detect
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sampled,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] t0,
    input  logic [NPINS-1:0] t1,
    input  logic [NPINS-1:0] t2,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status,
    output logic             irq
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] pin_event;

    // Remember the last synchronized sample for edge comparison
    always_ff @(posedge clk) begin : p_history
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sampled;
        end
    end

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            logic rise;
            logic fall;
            logic hit;
            assign rise = sampled[i] & ~prev_q[i];
            assign fall = ~sampled[i] & prev_q[i];

            // Decode this pin's trigger code into an event strobe
            always_comb begin : p_decode
                case ({t2[i], t1[i], t0[i]})
                    TRIG_FALL: hit = fall;
                    TRIG_RISE: hit = rise;
                    TRIG_BOTH: hit = rise | fall;
                    TRIG_LOW:  hit = ~sampled[i];
                    TRIG_HIGH: hit = sampled[i];
                    default:   hit = t1[i] ? (sampled[i] == t0[i]) : (rise | fall);
                endcase
            end

            assign pin_event[i] = hit;
        end
    endgenerate

    // Accumulate enabled events; a write-one clear takes priority
    always_ff @(posedge clk) begin : p_status
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status | (pin_event & en)) & ~clr;
        end
    end

    assign irq = |(status & en);

    // R8: any bit named in a clear is zero at the next edge
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((status & $past(clr)) == '0));

    // R7: a bit that was clear and disabled cannot become set
    assert_gate_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(en)) == '0));

    // R6: an enabled, active level without a clear leaves its bit set
    assert_level_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(t1 & en & ~clr & ~(t0 ^ sampled))) ==
                  $past(t1 & en & ~clr & ~(t0 ^ sampled))));

    // R5: one-sided edge modes ignore the opposite edge on clear, enabled bits
    assert_rise_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) &
                   $past(~t2 & ~t1 & t0 & ~sampled & prev_q)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
// Module gpio_irq_bank
// Top of the GPIO bank: it joins the pad synchronizer, the register file and
// the interrupt detector. Pad drivers, pin muxing and debouncing live outside.
// Assumes a single clock and synchronous active-low reset.
module gpio_irq_bank #(
    parameter int NPINS       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_out
);

    logic [NPINS-1:0] pin_sampled;
    logic [NPINS-1:0] irq_status;
    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] t0_q;
    logic [NPINS-1:0] t1_q;
    logic [NPINS-1:0] t2_q;
    logic [NPINS-1:0] clr_mask;

    gpio_pad_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .d_sync  (pin_sampled)
    );

    gpio_bank_regs #(
        .NPINS  (NPINS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_sampled (pin_sampled),
        .irq_status  (irq_status),
        .latch_q     (latch_q),
        .dir_q       (dir_q),
        .en_q        (en_q),
        .t0_q        (t0_q),
        .t1_q        (t1_q),
        .t2_q        (t2_q),
        .clr_mask    (clr_mask)
    );

    gpio_irq_detect #(
        .NPINS (NPINS)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sampled (pin_sampled),
        .en      (en_q),
        .t0      (t0_q),
        .t1      (t1_q),
        .t2      (t2_q),
        .clr     (clr_mask),
        .status  (irq_status),
        .irq     (irq_out)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;

    // R9: the combined request needs at least one enabled pin
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q != '0));

    // R9: the combined request needs at least one pending status bit
    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_status != '0));

endmodule

// File: tb/gpio_irq_bank_bench.sv
// Bench for gpio_irq_bank. Inputs change 1 ns after a rising edge and outputs
// are checked on the falling edge. A requirement-level model runs alongside and
// is compared every cycle. Directed steps check literal values.
module gpio_irq_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    gpio_irq_bank u_gpio_irq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_out   (irq_out)
    );

    // Requirement-level model state
    logic [31:0] m_s1, m_s2, m_prev, m_lat, m_dir, m_en, m_t0, m_t1, m_t2, m_st;

    function automatic logic [31:0] ev_f(input logic [31:0] s, p, a0, a1, a2);
        logic [31:0] rise, fall, lvl, edg;
        rise = s & ~p;
        fall = ~s & p;
        lvl  = ~(s ^ a0);
        edg  = (a2 & (rise | fall)) | (~a2 & ((a0 & rise) | (~a0 & fall)));
        return (a1 & lvl) | (~a1 & edg);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00:   return m_s2;
            8'h04:   return m_dir;
            8'h08:   return m_lat;
            8'h10:   return m_en;
            8'h14:   return m_t0;
            8'h18:   return m_t1;
            8'h1C:   return m_t2;
            8'h20:   return m_st;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        case (a)
            8'h00:   return "R4 value read";
            8'h04:   return "R3 direction read";
            8'h08:   return "R2 latch read";
            8'h20:   return "R8 status read";
            default: return "R10 register read";
        endcase
    endfunction

    // Advance the model with the inputs held since the last drive point
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_lat <= '0; m_dir <= '0;
            m_en <= '0; m_t0 <= '0; m_t1 <= '0; m_t2 <= '0; m_st <= '0;
        end else begin
            m_s1   <= pad_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_st   <= (m_st | (ev_f(m_s2, m_prev, m_t0, m_t1, m_t2) & m_en)) &
                      ~((bus_wr && bus_addr == 8'h20) ? bus_wdata : 32'h0);
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_lat <= bus_wdata;
                    8'h04: m_dir <= bus_wdata;
                    8'h10: m_en  <= bus_wdata;
                    8'h14: m_t0  <= bus_wdata;
                    8'h18: m_t1  <= bus_wdata;
                    8'h1C: m_t2  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq_out vs model", {31'b0, irq_out}, {31'b0, |(m_st & m_en)});
            chk("R2 pad_out vs model", pad_out, m_lat);
            chk("R3 pad_oe vs model", pad_oe, m_dir);
            chk(tag_for(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd7321));
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 pad_oe after reset", pad_oe, 32'h0);
        chk("R1 pad_out after reset", pad_out, 32'h0);
        chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
        rd(8'h20, r); chk("R1 status after reset", r, 32'h0);
        rd(8'h04, r); chk("R1 direction after reset", r, 32'h0);

        // R2 latch write, readback, read-only readback register
        idle(1);
        wr(8'h00, 32'hA5A5_0F0F);
        chk("R2 pad_out follows latch", pad_out, 32'hA5A5_0F0F);
        rd(8'h08, r); chk("R2 latch readback", r, 32'hA5A5_0F0F);
        idle(1);
        wr(8'h08, 32'h0);
        rd(8'h08, r); chk("R2 write to readback ignored", r, 32'hA5A5_0F0F);

        // R3 direction
        idle(1);
        wr(8'h04, 32'hFFFF_0000);
        chk("R3 pad_oe follows direction", pad_oe, 32'hFFFF_0000);

        // R4 two-stage synchronized value, pad level not latch
        pad_in = 32'h0000_00F0;
        idle(1);
        rd(8'h00, r); chk("R4 value not yet after one edge", r, 32'h0);
        idle(1);
        rd(8'h00, r); chk("R4 value after two edges", r, 32'h0000_00F0);

        // Trigger modes: pin0 fall, pin1 rise, pin2 both, pin3 low, pin4 high
        pad_in = 32'h9;
        idle(4);
        wr(8'h14, 32'h16);
        wr(8'h18, 32'h18);
        wr(8'h1C, 32'h04);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h10, 32'h1F);
        idle(3);
        rd(8'h20, r); chk("R5 no event while idle", r, 32'h0);
        idle(1);
        pad_in = 32'h6;
        idle(3);
        rd(8'h20, r); chk("R5 R6 edges and low level", r, 32'hF);
        chk("R9 irq_out with enabled status", {31'b0, irq_out}, 32'h1);
        idle(1);
        wr(8'h20, 32'h7);
        rd(8'h20, r); chk("R8 clear edge bits only", r, 32'h8);
        idle(1);
        wr(8'h20, 32'h8);
        rd(8'h20, r); chk("R8 clear wins over level", r, 32'h0);
        idle(1);
        rd(8'h20, r); chk("R8 level re-asserts", r, 32'h8);
        idle(1);
        wr(8'h20, 32'h0);
        rd(8'h20, r); chk("R8 write of zero no effect", r, 32'h8);
        idle(1);
        pad_in = 32'h9;
        idle(3);
        rd(8'h20, r); chk("R5 only both-edge pin on reverse step", r, 32'hC);
        idle(1);
        wr(8'h20, 32'hC);
        rd(8'h20, r); chk("R8 clear after level released", r, 32'h0);
        idle(1);
        pad_in = 32'h19;
        idle(3);
        rd(8'h20, r); chk("R6 high level", r, 32'h10);

        // R9 masking and R7 gating
        idle(1);
        wr(8'h10, 32'h0);
        rd(8'h20, r); chk("R9 status kept when masked", r, 32'h10);
        chk("R9 irq_out masked", {31'b0, irq_out}, 32'h0);
        idle(1);
        wr(8'h20, 32'h10);
        idle(2);
        rd(8'h20, r); chk("R7 disabled level does not set", r, 32'h0);
        pad_in = 32'h1B;
        idle(3);
        rd(8'h20, r); chk("R7 disabled edge does not set", r, 32'h0);
        wr(8'h10, 32'h1F);
        idle(1);
        chk("R9 irq_out after re-enable", {31'b0, irq_out}, 32'h1);

        // R10 offsets and unmapped reads
        wr(8'h14, 32'h1234_5678);
        rd(8'h14, r); chk("R10 type0 readback", r, 32'h1234_5678);
        rd(8'h10, r); chk("R10 enable readback", r, 32'h1F);
        rd(8'h40, r); chk("R10 unmapped read", r, 32'h0);
        rd(8'h24, r); chk("R10 unmapped after status", r, 32'h0);

        // Random phase, checked every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            idle(1);
            pad_in = pad_in ^ ($urandom & $urandom & $urandom);
            case ($urandom % 10)
                0: bus_addr = 8'h00;
                1: bus_addr = 8'h04;
                2: bus_addr = 8'h08;
                3: bus_addr = 8'h10;
                4: bus_addr = 8'h14;
                5: bus_addr = 8'h18;
                6: bus_addr = 8'h1C;
                7: bus_addr = 8'h20;
                8: bus_addr = 8'h24;
                default: bus_addr = 8'h40;
            endcase
            bus_wdata = $urandom;
            bus_wr = (($urandom % 4) == 0);
        end
        idle(1);
        bus_wr = 1'b0;
        idle(2);
        finish_run();
    end

endmodule